// File: doc/BRIEF.md
# Privilege Mode Derivation Unit

This block keeps a 32-bit processor status word plus a one-bit debug flag, and from them it produces the current privilege level: kernel, supervisor or user. It also drives three permission enables for neighbouring logic. The first lets the core reach its system-control coprocessor. The second enables the floating-point unit. The third allows 64-bit address generation. Software changes the status word through a write port. Only the bits selected by a writable-bit mask are updated, and every other bit keeps its old value.

Four one-cycle event inputs move the level. These are exception entry, error/reset entry, debug entry and return-from-exception. The status word and the debug flag are registered. The level and the enables are decoded combinationally from the stored state, so every event or write shows up at the outputs in the cycle after the clock edge that captures it.

The decoder is written as a three-state selector. KERNEL is taken whenever an elevated level bit is set, and also as the fallback. USER is taken when the user bit is set. SUPERVISOR is taken when the user bit is clear and the supervisor bit is set. The level has no history of its own. Its transitions follow the stored bits: any entry event moves USER→KERNEL or SUPERVISOR→KERNEL. A return that clears the last elevated bit moves KERNEL→USER or KERNEL→SUPERVISOR. A status write moves between any two states.

Top module: `priv_mode_unit`

## Requirements
- R1: After reset the status word is 0x00400004 (error-level bit 2 and boot-vector bit 22 set), the debug flag is clear, the mode is kernel, the coprocessor-0 enable and the 64-bit enable are 1, and the FPU enable is 0.
- R2: The mode is kernel (2'b00) while status bit 1 (exception level), status bit 2 (error level) or the debug flag is set, whatever bits 3 and 4 hold.
- R3: With bit 1, bit 2 and the debug flag all clear, the mode is user (2'b10) if bit 4 is set, supervisor (2'b01) if bit 4 is clear and bit 3 is set, and kernel (2'b00) if both are clear. The value 2'b11 never appears.
- R4: The coprocessor-0 enable is 1 when status bit 28 is set or the mode is kernel. In supervisor or user mode with bit 28 clear it is 0.
- R5: The FPU enable equals status bit 29.
- R6: The 64-bit enable is 1 unless the mode is user and both status bit 23 and status bit 5 are clear.
- R7: A write loads the data bits selected by WR_MASK (default 0x30F8FF3F, which includes bit 3) and keeps every other bit. With the default mask, bit 31 is never changed by a write.
- R8: An exception-entry pulse sets bit 1. From the next cycle the mode is kernel and the coprocessor-0 and 64-bit enables are 1.
- R9: An error-entry pulse sets bit 2 and bit 22, and the mode becomes kernel on the next cycle.
- R10: A debug-entry pulse sets the debug flag and forces kernel mode. Status writes do not change the flag.
- R11: A return pulse clears the debug flag if it is set. Otherwise it clears bit 2 if that bit is set, and otherwise it clears bit 1. A return in the same cycle as any entry event is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 32 | Status write data, applied through WR_MASK |
| exc_entry_i | input | 1 | Exception entry pulse |
| err_entry_i | input | 1 | Error/reset entry pulse |
| dbg_entry_i | input | 1 | Debug entry pulse |
| eret_i | input | 1 | Return-from-exception pulse |
| status_o | output | 32 | Current status word |
| in_debug_o | output | 1 | Debug flag |
| mode_o | output | 2 | Privilege mode: 00 kernel, 01 supervisor, 10 user |
| cp0_en_o | output | 1 | System-coprocessor access enable |
| fpu_en_o | output | 1 | Floating-point unit enable |
| addr64_en_o | output | 1 | 64-bit addressing enable |

## Verification
The bench walks all 256 combinations of the eight bits the decoder reads, once with the debug flag clear and once with it set. It computes the mode and the three enables arithmetically for each. This catches a decoder that lets the supervisor bit beat the user bit, that grants kernel-only coprocessor access to supervisor, or that forgets the debug flag in the override. Directed sequences target the order in which a return unwinds the levels (debug first, then error, then exception) and a return that collides with an entry. A wrong order would leave the core in kernel mode with a stale bit, or drop it to user mode too early. The sweep also writes bit 31 and the supervisor bit on every step, so a mask that leaks or blocks a bit shows up as a status mismatch.

// File: rtl/priv_pkg.sv
package priv_pkg;
    localparam int STAT_W  = 32;
    localparam int BIT_EXL = 1;
    localparam int BIT_ERL = 2;
    localparam int BIT_SUP = 3;
    localparam int BIT_USR = 4;
    localparam int BIT_UX  = 5;
    localparam int BIT_BEV = 22;
    localparam int BIT_PX  = 23;
    localparam int BIT_CU0 = 28;
    localparam int BIT_CU1 = 29;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'b00,
        MODE_SUPER  = 2'b01,
        MODE_USER   = 2'b10
    } mode_e;
endpackage

// File: rtl/priv_status_reg.sv
module priv_status_reg
    import priv_pkg::*;
#(
    parameter int                 W       = STAT_W,
    parameter logic [STAT_W-1:0]  WR_MASK = 32'h30F8FF3F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic          exc_entry_i,
    input  logic          err_entry_i,
    input  logic          dbg_entry_i,
    input  logic          eret_i,
    output logic [W-1:0]  stat_o,
    output logic          dbg_o
);
    localparam logic [W-1:0] RESET_VAL = (W'(1) << BIT_ERL) | (W'(1) << BIT_BEV);

    logic [W-1:0] stat_q, stat_d;
    logic         dbg_q, dbg_d;
    logic         any_entry;

    assign any_entry = exc_entry_i | err_entry_i | dbg_entry_i;

    always_comb begin
        stat_d = stat_q;
        dbg_d  = dbg_q;
        if (wr_en_i) begin
            stat_d = (wr_data_i & WR_MASK) | (stat_q & ~WR_MASK);
        end
        if (err_entry_i) begin
            stat_d[BIT_ERL] = 1'b1;
            stat_d[BIT_BEV] = 1'b1;
        end
        if (exc_entry_i) begin
            stat_d[BIT_EXL] = 1'b1;
        end
        if (dbg_entry_i) begin
            dbg_d = 1'b1;
        end
        if (eret_i && !any_entry) begin
            if (dbg_q) begin
                dbg_d = 1'b0;
            end else if (stat_q[BIT_ERL]) begin
                stat_d[BIT_ERL] = 1'b0;
            end else begin
                stat_d[BIT_EXL] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= RESET_VAL;
            dbg_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            dbg_q  <= dbg_d;
        end
    end

    assign stat_o = stat_q;
    assign dbg_o  = dbg_q;
endmodule

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
    import priv_pkg::*;
(
    input  logic  exl_i,
    input  logic  erl_i,
    input  logic  dbg_i,
    input  logic  sup_i,
    input  logic  usr_i,
    input  logic  cu0_i,
    input  logic  cu1_i,
    input  logic  px_i,
    input  logic  ux_i,
    output mode_e mode_o,
    output logic  cp0_en_o,
    output logic  fpu_en_o,
    output logic  addr64_en_o
);
    logic elevated;
    assign elevated = exl_i | erl_i | dbg_i;

    // State selection: override levels win, then the user bit, then supervisor.
    always_comb begin
        if (elevated) begin
            mode_o = MODE_KERNEL;
        end else if (usr_i) begin
            mode_o = MODE_USER;
        end else if (sup_i) begin
            mode_o = MODE_SUPER;
        end else begin
            mode_o = MODE_KERNEL;
        end
    end

    // Per-state enables.
    always_comb begin
        unique case (mode_o)
            MODE_KERNEL: begin
                cp0_en_o    = 1'b1;
                addr64_en_o = 1'b1;
            end
            MODE_SUPER: begin
                cp0_en_o    = cu0_i;
                addr64_en_o = 1'b1;
            end
            MODE_USER: begin
                cp0_en_o    = cu0_i;
                addr64_en_o = px_i | ux_i;
            end
            default: begin
                cp0_en_o    = 1'b1;
                addr64_en_o = 1'b1;
            end
        endcase
        fpu_en_o = cu1_i;
    end
endmodule

// File: rtl/priv_mode_unit.sv
module priv_mode_unit
    import priv_pkg::*;
#(
    parameter logic [STAT_W-1:0] WR_MASK = 32'h30F8FF3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic              exc_entry_i,
    input  logic              err_entry_i,
    input  logic              dbg_entry_i,
    input  logic              eret_i,
    output logic [STAT_W-1:0] status_o,
    output logic              in_debug_o,
    output logic [1:0]        mode_o,
    output logic              cp0_en_o,
    output logic              fpu_en_o,
    output logic              addr64_en_o
);
    logic [STAT_W-1:0] stat;
    logic              dbg;
    mode_e             mode;

    priv_status_reg #(
        .W       (STAT_W),
        .WR_MASK (WR_MASK)
    ) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .exc_entry_i (exc_entry_i),
        .err_entry_i (err_entry_i),
        .dbg_entry_i (dbg_entry_i),
        .eret_i      (eret_i),
        .stat_o      (stat),
        .dbg_o       (dbg)
    );

    priv_mode_decode u_dec (
        .exl_i       (stat[BIT_EXL]),
        .erl_i       (stat[BIT_ERL]),
        .dbg_i       (dbg),
        .sup_i       (stat[BIT_SUP]),
        .usr_i       (stat[BIT_USR]),
        .cu0_i       (stat[BIT_CU0]),
        .cu1_i       (stat[BIT_CU1]),
        .px_i        (stat[BIT_PX]),
        .ux_i        (stat[BIT_UX]),
        .mode_o      (mode),
        .cp0_en_o    (cp0_en_o),
        .fpu_en_o    (fpu_en_o),
        .addr64_en_o (addr64_en_o)
    );

    assign status_o   = stat;
    assign in_debug_o = dbg;
    assign mode_o     = mode;
endmodule

// File: rtl/priv_mode_checker.sv
module priv_mode_checker #(
    parameter bit TOP_BIT_LOCKED = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       exc_entry_i,
    input logic       err_entry_i,
    input logic       dbg_entry_i,
    input logic       eret_i,
    input logic       exl_b,
    input logic       erl_b,
    input logic       bev_b,
    input logic       cu0_b,
    input logic       top_b,
    input logic       in_debug_o,
    input logic [1:0] mode_o,
    input logic       cp0_en_o,
    input logic       addr64_en_o
);
    assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

    assert_override_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exl_b || erl_b || in_debug_o) |-> (mode_o == 2'b00));

    assert_super_no_cp0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && !cu0_b) |-> !cp0_en_o);

    assert_top_bit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        TOP_BIT_LOCKED |=> $stable(top_b));

    assert_exc_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry_i |=> (exl_b && mode_o == 2'b00 && cp0_en_o && addr64_en_o));

    assert_err_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_entry_i |=> (erl_b && bev_b && mode_o == 2'b00));

    assert_dbg_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_entry_i |=> (in_debug_o && mode_o == 2'b00));

    assert_eret_debug_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !exc_entry_i && !err_entry_i && !dbg_entry_i && in_debug_o)
        |=> (!in_debug_o && exl_b == $past(exl_b) && erl_b == $past(erl_b)));
endmodule

bind priv_mode_unit priv_mode_checker #(
    .TOP_BIT_LOCKED (!WR_MASK[31])
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_entry_i (exc_entry_i),
    .err_entry_i (err_entry_i),
    .dbg_entry_i (dbg_entry_i),
    .eret_i      (eret_i),
    .exl_b       (status_o[1]),
    .erl_b       (status_o[2]),
    .bev_b       (status_o[22]),
    .cu0_b       (status_o[28]),
    .top_b       (status_o[31]),
    .in_debug_o  (in_debug_o),
    .mode_o      (mode_o),
    .cp0_en_o    (cp0_en_o),
    .addr64_en_o (addr64_en_o)
);

// File: tb/tb_priv_mode_unit.sv
`timescale 1ns/1ps
module tb_priv_mode_unit;
    localparam logic [31:0] MASK = 32'h30F8FF3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        exc_e = 1'b0, err_e = 1'b0, dbg_e = 1'b0, eret = 1'b0;
    logic [31:0] status;
    logic        in_dbg, cp0_en, fpu_en, a64_en;
    logic [1:0]  mode;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_stat;
    logic        m_dbg;

    always #2.5 clk = ~clk;

    priv_mode_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .exc_entry_i (exc_e),
        .err_entry_i (err_e),
        .dbg_entry_i (dbg_e),
        .eret_i      (eret),
        .status_o    (status),
        .in_debug_o  (in_dbg),
        .mode_o      (mode),
        .cp0_en_o    (cp0_en),
        .fpu_en_o    (fpu_en),
        .addr64_en_o (a64_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(input logic [31:0] s, input logic d);
        if (s[1] || s[2] || d) return 2'b00;
        if (s[4]) return 2'b10;
        if (s[3]) return 2'b01;
        return 2'b00;
    endfunction

    task automatic check_all(input string ctx);
        logic [1:0] em;
        em = exp_mode(m_stat, m_dbg);
        chk({ctx, " status R7"}, status, m_stat);
        chk({ctx, " debug R10"}, {31'b0, in_dbg}, {31'b0, m_dbg});
        chk({ctx, " mode R2 R3"}, {30'b0, mode}, {30'b0, em});
        chk({ctx, " cp0 R4"}, {31'b0, cp0_en}, {31'b0, (m_stat[28] || em == 2'b00)});
        chk({ctx, " fpu R5"}, {31'b0, fpu_en}, {31'b0, m_stat[29]});
        chk({ctx, " a64 R6"}, {31'b0, a64_en}, {31'b0, (em != 2'b10 || m_stat[23] || m_stat[5])});
    endtask

    // One cycle of stimulus; outputs are compared half a period after the capturing edge.
    task automatic step(input logic we, input logic [31:0] wd, input logic ex,
                        input logic er, input logic db, input logic rt);
        logic [31:0] old;
        logic        any;
        @(negedge clk);
        wr_en = we; wr_data = wd; exc_e = ex; err_e = er; dbg_e = db; eret = rt;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; exc_e = 1'b0; err_e = 1'b0; dbg_e = 1'b0; eret = 1'b0;
        old = m_stat;
        any = ex | er | db;
        if (we) m_stat = (wd & MASK) | (m_stat & ~MASK);
        if (er) begin m_stat[2] = 1'b1; m_stat[22] = 1'b1; end
        if (ex) m_stat[1] = 1'b1;
        if (rt && !any) begin
            if (m_dbg) m_dbg = 1'b0;
            else if (old[2]) m_stat[2] = 1'b0;
            else m_stat[1] = 1'b0;
        end
        if (db) m_dbg = 1'b1;
    endtask

    task automatic sweep(input string ctx);
        for (int i = 0; i < 256; i++) begin
            logic [31:0] w;
            w = '0;
            w[1]  = i[0]; w[2]  = i[1]; w[3]  = i[2]; w[4] = i[3];
            w[28] = i[4]; w[29] = i[5]; w[23] = i[6]; w[5] = i[7];
            w[31] = i[0] ^ i[3];
            w[30] = i[2];
            w[15:8] = i[7:0];
            step(1'b1, w, 1'b0, 1'b0, 1'b0, 1'b0);
            check_all(ctx);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        m_stat = 32'h0040_0004;
        m_dbg  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", status, 32'h0040_0004);
        chk("R1 mode", {30'b0, mode}, 32'h0);
        chk("R1 cp0", {31'b0, cp0_en}, 32'h1);
        chk("R1 fpu", {31'b0, fpu_en}, 32'h0);
        chk("R1 a64", {31'b0, a64_en}, 32'h1);
        chk("R1 debug", {31'b0, in_dbg}, 32'h0);

        sweep("sweep-nodbg");

        // R10: debug entry, then the sweep again with the flag held
        step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_all("R10 dbg-entry");
        sweep("sweep-dbg R10");
        // R11: return leaves debug first
        step(1'b1, 32'h0000_0016, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_all("R11 eret-dbg");
        chk("R11 dbg cleared", {31'b0, in_dbg}, 32'h0);
        chk("R11 erl kept", {31'b0, status[2]}, 32'h1);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_all("R11 eret-erl");
        chk("R11 erl cleared", {31'b0, status[2]}, 32'h0);
        chk("R11 exl kept", {31'b0, status[1]}, 32'h1);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_all("R11 eret-exl");
        chk("R11 user again", {30'b0, mode}, 32'h2);

        // R8: exception from user mode, then return
        step(1'b1, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R8 exc");
        chk("R8 kernel", {30'b0, mode}, 32'h0);
        chk("R8 cp0", {31'b0, cp0_en}, 32'h1);
        chk("R8 a64", {31'b0, a64_en}, 32'h1);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_all("R11 back-to-user");

        // R11: return colliding with entry is ignored
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
        check_all("R11 collide");
        chk("R11 exl set", {31'b0, status[1]}, 32'h1);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);

        // R9: error entry from supervisor mode
        step(1'b1, 32'h0000_0008, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 super", {30'b0, mode}, 32'h1);
        chk("R4 super cp0", {31'b0, cp0_en}, 32'h0);
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R9 err");
        chk("R9 erl+bev", status & 32'h0040_0004, 32'h0040_0004);
        chk("R9 kernel", {30'b0, mode}, 32'h0);

        // R7: unmasked top bit ignores a write of all ones
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R7 all-ones");
        chk("R7 bit31", {31'b0, status[31]}, 32'h0);
        chk("R7 bit30", {31'b0, status[30]}, 32'h0);

        summary();
        $finish;
    end
endmodule